// File: doc/BRIEF.md
# Range-Limited Triangular Averaging Filter

This block smooths a stream of signed rate samples with a finite impulse response filter whose coefficients form a triangle. The filter length is a power of two, N = 2^M, and M is set through a 16-bit configuration word. The same word also holds a one-hot measurement-range code. The narrower ranges need more smoothing, so each range sets a lowest allowed M. The block raises any smaller M to that floor before it uses it, and the raised value is what reads back.

The triangle is made from two running boxcar sums, each of length N/2, placed one after the other. Their combined gain is (N/2)^2, and the block divides that gain out. Any write to the configuration word clears the filter history. After a write, the output strobe stays low until N new samples have come in. Software should write the range first and the filter length second.

Top module: `bart_filter`

## Requirements
- R1: After reset, the configuration readback is 0x0400 (widest range, M = 0) and `out_valid` is low.
- R2: The readback word has the range code in bits 10:8 and the effective M in bits 3:0. Bits 15:11 and 7:4 read back as zero whatever was written.
- R3: Written bits 10:8 select the range. 3'b100 is the widest range, 3'b010 the middle range and 3'b001 the narrowest range. Any other code leaves the range unchanged, while the M field of the same write still takes effect.
- R4: If the range is middle, the effective M is at least 2. If the range is narrowest, the effective M is at least 4. A smaller written M is raised to that floor.
- R5: A written M above 7 is saturated to 7 (N = 128).
- R6: Let L = N/2 and let x[n-j] be the sample accepted j samples before the current one. For M ≥ 1 the output is the sum of w_j·x[n-j] over j = 0..2L-2, where w_j = min(j+1, 2L-1-j). That sum is divided by L² and truncated toward zero. History from before the last write counts as zero. For M = 0 the output equals the input sample. For M = 1 the output also equals the input sample, because the window then has a single tap.
- R7: Each sample taken with `in_valid` high gives at most one `out_valid` pulse. The pulse comes in the cycle after the sample.
- R8: After a configuration write, `out_valid` stays low until N samples have been accepted. It is high for the N-th sample and for every sample after it.
- R9: A configuration write clears all filter history. A sample presented in the same cycle as a write is discarded, and no output follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write word |
| cfg_rdata | output | 16 | Configuration readback |
| out_valid | output | 1 | Filtered sample strobe |
| out_data | output | 16 | Signed filtered sample |

## Verification
The two running sums are updated recursively, so a corrupted sum or a wrong tap from a delay line gives an output error that never fades. It persists until the next configuration write and is compared against the reference on the very next valid output. A wrong delay-line tap shows within L samples, as soon as the sample that should have left the window is subtracted. A wrong warm-up count shows as an early or late `out_valid` within N samples of a write. A wrong clamp shows on `cfg_rdata` one cycle after the write.

// File: rtl/bart_pkg.sv
package bart_pkg;
    localparam logic [2:0] RNG_WIDE   = 3'b100;
    localparam logic [2:0] RNG_MID    = 3'b010;
    localparam logic [2:0] RNG_NARROW = 3'b001;

    typedef struct packed {
        logic [2:0] rng;
        logic [3:0] m;
    } cfg_t;

    function automatic logic rng_code_ok(logic [2:0] code);
        return (code == RNG_WIDE) || (code == RNG_MID) || (code == RNG_NARROW);
    endfunction

    function automatic logic [3:0] rng_floor(logic [2:0] code);
        case (code)
            RNG_MID:    return 4'd2;
            RNG_NARROW: return 4'd4;
            default:    return 4'd0;
        endcase
    endfunction
endpackage

// File: rtl/bart_cfg.sv
module bart_cfg
    import bart_pkg::*;
#(
    parameter int M_MAX = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [15:0] wdata,
    output logic [2:0]  rng,
    output logic [3:0]  m,
    output logic [15:0] rdata
);
    localparam logic [3:0] M_TOP = 4'(M_MAX);

    cfg_t       cfg_d, cfg_q;
    logic [2:0] rng_new;
    logic [3:0] m_req;
    logic       unused_wbits;

    assign unused_wbits = ^{wdata[15:11], wdata[7:4]};

    always_comb begin
        cfg_d   = cfg_q;
        rng_new = rng_code_ok(wdata[10:8]) ? wdata[10:8] : cfg_q.rng;
        m_req   = (wdata[3:0] > M_TOP) ? M_TOP : wdata[3:0];
        if (m_req < rng_floor(rng_new)) begin
            m_req = rng_floor(rng_new);
        end
        if (we) begin
            cfg_d.rng = rng_new;
            cfg_d.m   = m_req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{rng: RNG_WIDE, m: 4'd0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign rng   = cfg_q.rng;
    assign m     = cfg_q.m;
    assign rdata = {5'd0, cfg_q.rng, 4'd0, cfg_q.m};
endmodule

// File: rtl/bart_dly.sv
module bart_dly #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 64,
    localparam int SEL_W = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    shift,
    input  logic signed [WIDTH-1:0] din,
    input  logic [SEL_W-1:0]        sel,
    output logic signed [WIDTH-1:0] tap
);
    logic signed [WIDTH-1:0] mem_d [DEPTH];
    logic signed [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (clr) begin
            for (int i = 0; i < DEPTH; i++) mem_d[i] = '0;
        end else if (shift) begin
            mem_d[0] = din;
            for (int i = 1; i < DEPTH; i++) mem_d[i] = mem_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign tap = mem_q[sel];
endmodule

// File: rtl/bart_filter.sv
module bart_filter #(
    parameter int DATA_W = 16,
    parameter int M_MAX  = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    input  logic                     cfg_we,
    input  logic [15:0]              cfg_wdata,
    output logic [15:0]              cfg_rdata,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);
    localparam int LG    = M_MAX - 1;
    localparam int LMAX  = 1 << LG;
    localparam int S1_W  = DATA_W + LG;
    localparam int S2_W  = DATA_W + 2 * LG;
    localparam int CNT_W = M_MAX + 1;

    typedef struct packed {
        logic signed [S1_W-1:0]   s1;
        logic signed [S2_W-1:0]   s2;
        logic [CNT_W-1:0]         cnt;
        logic                     ovld;
        logic signed [DATA_W-1:0] odata;
    } st_t;

    st_t st_d, st_q;

    logic [2:0]               rng_cur;
    logic [3:0]               m_cur;
    logic [LG-1:0]            tap_sel;
    logic                     accept;
    logic signed [DATA_W-1:0] x_tap;
    logic signed [S1_W-1:0]   s1_tap;
    logic signed [S1_W-1:0]   s1_new;
    logic signed [S2_W-1:0]   s2_new;
    logic signed [S2_W-1:0]   bias;
    logic signed [S2_W-1:0]   rounded;
    logic signed [S2_W-1:0]   scaled;
    logic [CNT_W-1:0]         cnt_inc;
    logic [CNT_W-1:0]         n_need;
    int                       shamt;
    logic                     unused_sig;

    bart_cfg #(.M_MAX(M_MAX)) cfg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rng   (rng_cur),
        .m     (m_cur),
        .rdata (cfg_rdata)
    );

    assign accept  = in_valid && !cfg_we;
    assign tap_sel = (m_cur == 4'd0) ? '0 : LG'((1 << (int'(m_cur) - 1)) - 1);

    bart_dly #(.WIDTH(DATA_W), .DEPTH(LMAX)) dly_x_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_we),
        .shift (accept),
        .din   (in_data),
        .sel   (tap_sel),
        .tap   (x_tap)
    );

    bart_dly #(.WIDTH(S1_W), .DEPTH(LMAX)) dly_s1_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_we),
        .shift (accept),
        .din   (s1_new),
        .sel   (tap_sel),
        .tap   (s1_tap)
    );

    assign unused_sig = ^{rng_cur, scaled[S2_W-1:DATA_W]};

    always_comb begin
        st_d      = st_q;
        st_d.ovld = 1'b0;
        s1_new  = st_q.s1 + S1_W'(in_data) - S1_W'(x_tap);
        s2_new  = st_q.s2 + S2_W'(s1_new) - S2_W'(s1_tap);
        shamt   = (m_cur == 4'd0) ? 0 : 2 * (int'(m_cur) - 1);
        bias    = $signed((S2_W'(1) << shamt) - S2_W'(1));
        rounded = s2_new + (s2_new[S2_W-1] ? bias : S2_W'(0));
        scaled  = rounded >>> shamt;
        n_need  = CNT_W'(1) << m_cur;
        cnt_inc = (st_q.cnt == '1) ? st_q.cnt : st_q.cnt + CNT_W'(1);
        if (cfg_we) begin
            st_d.s1  = '0;
            st_d.s2  = '0;
            st_d.cnt = '0;
        end else if (in_valid) begin
            st_d.s1    = s1_new;
            st_d.s2    = s2_new;
            st_d.cnt   = cnt_inc;
            st_d.ovld  = (cnt_inc >= n_need);
            st_d.odata = (m_cur == 4'd0) ? in_data : scaled[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.ovld;
    assign out_data  = st_q.odata;
endmodule

// File: rtl/bart_filter_chk.sv
module bart_filter_chk #(
    parameter int M_MAX = 7
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        cfg_we,
    input logic [15:0] cfg_wdata,
    input logic [15:0] cfg_rdata,
    input logic        out_valid
);
    // R2
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[15:11] == 5'd0) && (cfg_rdata[7:4] == 4'd0));

    // R3
    range_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cfg_rdata[10:8]) == 1);

    // R3
    range_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !bart_pkg::rng_code_ok(cfg_wdata[10:8])) |=> $stable(cfg_rdata[10:8]));

    // R4
    floor_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[10:8] == 3'b010) |-> (cfg_rdata[3:0] >= 4'd2));

    // R4
    floor_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[10:8] == 3'b001) |-> (cfg_rdata[3:0] >= 4'd4));

    // R5
    m_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[3:0] <= 4'(M_MAX));

    // R7
    valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && !cfg_we));

    // R9
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !out_valid);
endmodule

bind bart_filter bart_filter_chk #(.M_MAX(M_MAX)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .out_valid (out_valid)
);

// File: tb/bart_filter_tb_top.sv
module bart_filter_tb_top;
    logic               clk = 1'b0;
    logic               rst_n;
    logic               in_valid;
    logic signed [15:0] in_data;
    logic               cfg_we;
    logic [15:0]        cfg_wdata;
    logic [15:0]        cfg_rdata;
    logic               out_valid;
    logic signed [15:0] out_data;

    always #5 clk = ~clk;

    bart_filter dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    int   m_ref;
    int   rng_ref;
    int   cnt_ref;
    int   hist[$];
    bit   exp_v;
    int   exp_d;

    task automatic check(string req, string what, longint act, longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int model_out();
        longint acc = 0;
        int     l;
        if (m_ref == 0) return hist[0];
        l = 1 << (m_ref - 1);
        for (int j = 0; j <= 2 * l - 2; j++) begin
            int w = (j + 1 < 2 * l - 1 - j) ? j + 1 : 2 * l - 1 - j;
            if (j < hist.size()) acc += longint'(w) * hist[j];
        end
        return int'(acc / (longint'(l) * l));
    endfunction

    task automatic step(bit we, logic [15:0] wd, bit v, int x, string req);
        int fl;
        int wm;
        cfg_we    = we;
        cfg_wdata = wd;
        in_valid  = v;
        in_data   = x[15:0];
        if (we) begin
            if (wd[10:8] == 3'b100 || wd[10:8] == 3'b010 || wd[10:8] == 3'b001)
                rng_ref = int'(wd[10:8]);
            fl = (rng_ref == 2) ? 2 : (rng_ref == 1) ? 4 : 0;
            wm = int'(wd[3:0]);
            if (wm > 7) wm = 7;
            if (wm < fl) wm = fl;
            m_ref   = wm;
            cnt_ref = 0;
            hist.delete();
            exp_v = 1'b0;
        end else if (v) begin
            hist.push_front(x);
            if (hist.size() > 200) void'(hist.pop_back());
            cnt_ref++;
            exp_v = (cnt_ref >= (1 << m_ref));
            exp_d = model_out();
        end else begin
            exp_v = 1'b0;
        end
        @(posedge clk);
        #1;
        check(req, "cfg_rdata", longint'(cfg_rdata),
              longint'({5'd0, 3'(rng_ref), 4'd0, 4'(m_ref)}));
        check(req, "out_valid", longint'(out_valid), longint'(exp_v));
        if (exp_v) check(req, "out_data", longint'(out_data), longint'(exp_d));
        @(negedge clk);
    endtask

    function automatic int rnd();
        return int'($urandom_range(0, 65535)) - 32768;
    endfunction

    task automatic stream(int n, string req, bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 3 == 1)) step(1'b0, 16'h0, 1'b0, 0, req);
            step(1'b0, 16'h0, 1'b1, rnd(), req);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R1..R9 run: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; cfg_we = 1'b0; cfg_wdata = '0;
        m_ref = 0; rng_ref = 4; cnt_ref = 0; exp_v = 1'b0; exp_d = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1", "cfg_rdata", longint'(cfg_rdata), 64'h0400);
        check("R1", "out_valid", longint'(out_valid), 0);
        @(negedge clk);

        // R6: M = 0 pass-through, R7 single pulse with gaps
        stream(5, "R6", 1'b0);
        stream(4, "R7", 1'b1);
        // R6: M = 1 single-tap window
        step(1'b1, 16'h0401, 1'b0, 0, "R6");
        stream(6, "R6", 1'b0);
        // R3: middle range, M = 3; R8 warm-up of eight samples
        step(1'b1, 16'h0203, 1'b0, 0, "R3");
        stream(8, "R8", 1'b1);
        stream(20, "R6", 1'b1);
        // R4: middle floor raises M = 0 to 2
        step(1'b1, 16'h0200, 1'b0, 0, "R4");
        stream(10, "R7", 1'b1);
        // R4: narrow floor raises M = 1 to 4
        step(1'b1, 16'h0101, 1'b0, 0, "R4");
        stream(24, "R8", 1'b0);
        // R5: M = 15 saturates to 7, long random run and extreme values
        step(1'b1, 16'h010F, 1'b0, 0, "R5");
        stream(300, "R6", 1'b1);
        for (int i = 0; i < 140; i++) step(1'b0, 16'h0, 1'b1, 32767, "R6");
        for (int i = 0; i < 140; i++) step(1'b0, 16'h0, 1'b1, -32768, "R6");
        // R3: invalid code 111 keeps narrow range, M = 5 taken
        step(1'b1, 16'h0705, 1'b0, 0, "R3");
        stream(40, "R6", 1'b0);
        // R2: junk in unused bits, range 010, M = 0 raised to 2
        step(1'b1, 16'hFAF0, 1'b0, 0, "R2");
        stream(10, "R6", 1'b1);
        // R9: sample with write is dropped, history cleared
        step(1'b1, 16'h0402, 1'b1, 12345, "R9");
        stream(6, "R9", 1'b0);
        // R3: code 000 keeps wide range
        step(1'b1, 16'h0006, 1'b0, 0, "R3");
        stream(80, "R6", 1'b0);
        step(1'b0, 16'h0, 1'b0, 0, "R7");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule